// File: doc/BRIEF.md
# Multiply-Accumulate Output Stage

This block sits directly behind a bank of multipliers and forms the first adder level of the output path. Each channel receives two products. In pair mode it adds or subtracts the two products. In accumulate mode it folds one product stream into a wide accumulator that feeds back on itself. A synchronous load replaces the running total with the current product. A registered flag marks each accumulation step that leaves the representable range, in the upward or downward direction.

The add/subtract selects, the load requests and the two operand-sign controls each pass through their own pipeline of zero, one or two registers, chosen by parameter. This lets each control meet the product it belongs to when the multiplier data path is pipelined. A clock enable freezes every register in the block. A synchronous clear zeroes the results and flags.

Top module: `mac_out_stage`

## Requirements
- R1: While `rst_ni` is low, every `res_o` lane and every `ovf_o` bit is 0.
- R2: When `accum_i` is 0, on each enabled edge a channel registers x+y if its add select is 1, or x−y (modulo 2^ACC_W) if it is 0. Its `ovf_o` bit is registered as 0.
- R3: When `accum_i` is 1 and no load is in effect, on each enabled edge a channel registers its previous result plus x if its add select is 1, or minus x if it is 0.
- R4: When `accum_i` is 1, an effective load makes the channel register the extended x in place of the sum, and its `ovf_o` bit becomes 0 on the same edge.
- R5: The add select, load and sign controls that act on an edge are the values sampled ADD_DLY, LOAD_DLY and SIGN_DLY enabled edges earlier. A depth of 0 uses the value present at that edge.
- R6: A product is sign-extended to ACC_W bits when either effective sign control is 1. Otherwise it is zero-extended.
- R7: With signed operands, `ovf_o` is set after an accumulation step whose exact result lies outside [−2^(ACC_W−1), 2^(ACC_W−1)−1].
- R8: With unsigned operands, `ovf_o` is set after an accumulation step that carries out of ACC_W bits (addition) or borrows (subtraction).
- R9: `ovf_o` is not sticky. Each enabled update rewrites it from that step alone.
- R10: `clr_i` high zeroes `res_o` and `ovf_o` at the next edge, regardless of `ce_i`.
- R11: With `ce_i` low and `clr_i` low, results, flags and all control pipelines hold their values.
- R12: Channel c uses only `add_i[c]`, `load_i[c]` and its own products, so channels evolve independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable for all registers |
| clr_i | input | 1 | Synchronous clear of results and flags |
| accum_i | input | 1 | 1 = accumulate, 0 = pair add/subtract |
| add_i | input | NUM_CH | Per-channel select, 1 = add, 0 = subtract |
| load_i | input | NUM_CH | Per-channel accumulator load request |
| sign_a_i | input | 1 | Operand A is signed |
| sign_b_i | input | 1 | Operand B is signed |
| prod_x_i | input | NUM_CH×PROD_W | First product per channel (accumulated operand) |
| prod_y_i | input | NUM_CH×PROD_W | Second product per channel (pair mode only) |
| res_o | output | NUM_CH×ACC_W | Registered result per channel |
| ovf_o | output | NUM_CH | Registered overflow/underflow flag per channel |

## Verification
Products reach `res_o` and `ovf_o` one clock edge after they are presented. Each control acts on the edge that comes its own pipeline depth of enabled edges after it was driven. The bench drives inputs on the falling edge. A behavioural model applies the rising edge with per-control histories that advance only on enabled edges. Both outputs are compared at the next falling edge, so every result is checked in the cycle it is due, whatever the mix of delay depths.

// File: rtl/mac_out_pkg.sv
package mac_out_pkg;
  typedef enum logic [1:0] {
    OP_PAIR = 2'd0,
    OP_LOAD = 2'd1,
    OP_ACC  = 2'd2
  } op_e;
endpackage

// File: rtl/mac_ctrl_dly.sv
module mac_ctrl_dly #(
  parameter int W     = 1,
  parameter int DEPTH = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_comb
    logic unused_dly;
    assign unused_dly = ^{clk_i, rst_ni, ce_i};
    assign q_o = d_i;
  end else begin : g_pipe
    logic [DEPTH-1:0][W-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= '0;
      end else if (ce_i) begin
        pipe_q[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
      end
    end
    assign q_o = pipe_q[DEPTH-1];
  end
endmodule

// File: rtl/mac_lane.sv
module mac_lane
  import mac_out_pkg::*;
#(
  parameter int PROD_W = 36,
  parameter int ACC_W  = 52
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              clr_i,
  input  op_e               op_i,
  input  logic              add_i,
  input  logic              sgn_i,
  input  logic [PROD_W-1:0] x_i,
  input  logic [PROD_W-1:0] y_i,
  output logic [ACC_W-1:0]  res_o,
  output logic              ovf_o
);
  localparam int EXT_W = ACC_W - PROD_W;

  logic [ACC_W-1:0] ext_x, ext_y, op_a, op_b, res_q;
  logic [ACC_W:0]   sum;
  logic             a_msb, b_msb, r_msb, s_ovf, ovf_d, ovf_q;

  assign ext_x = {{EXT_W{sgn_i & x_i[PROD_W-1]}}, x_i};
  assign ext_y = {{EXT_W{sgn_i & y_i[PROD_W-1]}}, y_i};

  // accumulate: feedback is operand a, product is operand b
  assign op_a = (op_i == OP_ACC) ? res_q : ext_x;
  assign op_b = (op_i == OP_ACC) ? ext_x : ext_y;

  assign sum = add_i ? ({1'b0, op_a} + {1'b0, op_b})
                     : ({1'b0, op_a} - {1'b0, op_b});

  assign a_msb = op_a[ACC_W-1];
  assign b_msb = op_b[ACC_W-1];
  assign r_msb = sum[ACC_W-1];
  assign s_ovf = add_i ? ((a_msb == b_msb) && (r_msb != a_msb))
                       : ((a_msb != b_msb) && (r_msb != a_msb));

  // bit ACC_W is carry on add, borrow on subtract
  assign ovf_d = (op_i == OP_ACC) && (sgn_i ? s_ovf : sum[ACC_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else if (ce_i) begin
      res_q <= (op_i == OP_LOAD) ? ext_x : sum[ACC_W-1:0];
      ovf_q <= ovf_d;
    end
  end

  assign res_o = res_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/mac_out_stage.sv
module mac_out_stage
  import mac_out_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int PROD_W   = 36,
  parameter int ACC_W    = 52,
  parameter int ADD_DLY  = 0,
  parameter int SIGN_DLY = 0,
  parameter int LOAD_DLY = 0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           ce_i,
  input  logic                           clr_i,
  input  logic                           accum_i,
  input  logic [NUM_CH-1:0]              add_i,
  input  logic [NUM_CH-1:0]              load_i,
  input  logic                           sign_a_i,
  input  logic                           sign_b_i,
  input  logic [NUM_CH-1:0][PROD_W-1:0]  prod_x_i,
  input  logic [NUM_CH-1:0][PROD_W-1:0]  prod_y_i,
  output logic [NUM_CH-1:0][ACC_W-1:0]   res_o,
  output logic [NUM_CH-1:0]              ovf_o
);
  logic [NUM_CH-1:0] add_q, load_q;
  logic [1:0]        sign_q;
  logic              sgn;

  mac_ctrl_dly #(.W(NUM_CH), .DEPTH(ADD_DLY)) u_add_dly (
    .clk_i, .rst_ni, .ce_i, .d_i(add_i), .q_o(add_q)
  );

  mac_ctrl_dly #(.W(NUM_CH), .DEPTH(LOAD_DLY)) u_load_dly (
    .clk_i, .rst_ni, .ce_i, .d_i(load_i), .q_o(load_q)
  );

  mac_ctrl_dly #(.W(2), .DEPTH(SIGN_DLY)) u_sign_dly (
    .clk_i, .rst_ni, .ce_i, .d_i({sign_a_i, sign_b_i}), .q_o(sign_q)
  );

  assign sgn = |sign_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    op_e op;
    assign op = !accum_i ? OP_PAIR : (load_q[c] ? OP_LOAD : OP_ACC);

    mac_lane #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_lane (
      .clk_i, .rst_ni, .ce_i, .clr_i,
      .op_i (op),
      .add_i(add_q[c]),
      .sgn_i(sgn),
      .x_i  (prod_x_i[c]),
      .y_i  (prod_y_i[c]),
      .res_o(res_o[c]),
      .ovf_o(ovf_o[c])
    );
  end
endmodule

// File: rtl/mac_out_stage_chk.sv
module mac_out_stage_chk #(
  parameter int NUM_CH = 2,
  parameter int ACC_W  = 52
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         ce_i,
  input logic                         clr_i,
  input logic                         accum_i,
  input logic [NUM_CH-1:0]            add_d_i,
  input logic [NUM_CH-1:0]            load_d_i,
  input logic                         sgn_d_i,
  input logic [NUM_CH-1:0][ACC_W-1:0] res_i,
  input logic [NUM_CH-1:0]            ovf_i
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R10
    a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (res_i[c] == '0) && !ovf_i[c]);
    // R11
    a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ce_i && !clr_i) |=> ($stable(res_i[c]) && $stable(ovf_i[c])));
    // R4
    a_r4_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ce_i && !clr_i && accum_i && load_d_i[c]) |=> !ovf_i[c]);
    // R2
    a_r2_pair_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ce_i && !clr_i && !accum_i) |=> !ovf_i[c]);
    // R8
    a_r8_unsigned_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ce_i && !clr_i && accum_i && !load_d_i[c] && add_d_i[c] && !sgn_d_i)
        |=> (ovf_i[c] || (res_i[c] >= $past(res_i[c]))));
  end
endmodule

bind mac_out_stage mac_out_stage_chk #(.NUM_CH(NUM_CH), .ACC_W(ACC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ce_i    (ce_i),
  .clr_i   (clr_i),
  .accum_i (accum_i),
  .add_d_i (add_q),
  .load_d_i(load_q),
  .sgn_d_i (sgn),
  .res_i   (res_o),
  .ovf_i   (ovf_o)
);

// File: tb/tb_mac_out_stage.sv
module tb_mac_out_stage;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int PW = 16;
  localparam int AW = 20;
  localparam int AD = 1;
  localparam int SD = 0;
  localparam int LD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, clr = 1'b0, accum = 1'b0, sa = 1'b0, sb = 1'b0;
  logic [NC-1:0] add = '0, load = '0;
  logic [NC-1:0][PW-1:0] px = '0, py = '0;
  logic [NC-1:0][AW-1:0] res;
  logic [NC-1:0] ovf;

  int tests = 0, fails = 0;
  bit done = 0;
  string phase = "R1 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_out_stage #(.NUM_CH(NC), .PROD_W(PW), .ACC_W(AW),
                  .ADD_DLY(AD), .SIGN_DLY(SD), .LOAD_DLY(LD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .clr_i(clr), .accum_i(accum),
    .add_i(add), .load_i(load), .sign_a_i(sa), .sign_b_i(sb),
    .prod_x_i(px), .prod_y_i(py), .res_o(res), .ovf_o(ovf)
  );

  // reference model
  logic [AW-1:0] m_res [NC];
  logic          m_ovf [NC];
  logic          h_add [NC][0:2];
  logic          h_ld  [NC][0:2];
  logic          h_sa [0:2];
  logic          h_sb [0:2];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_res[c] = '0; m_ovf[c] = 0;
        for (int k = 0; k < 3; k++) begin h_add[c][k] = 0; h_ld[c][k] = 0; end
      end
      for (int k = 0; k < 3; k++) begin h_sa[k] = 0; h_sb[k] = 0; end
    end else begin
      logic e_sa, e_sb, sg;
      e_sa = (SD == 0) ? sa : h_sa[SD];
      e_sb = (SD == 0) ? sb : h_sb[SD];
      sg = e_sa | e_sb;
      for (int c = 0; c < NC; c++) begin
        logic e_add, e_ld;
        longint vx, vy, cur, r;
        e_add = (AD == 0) ? add[c] : h_add[c][AD];
        e_ld  = (LD == 0) ? load[c] : h_ld[c][LD];
        vx = sg ? longint'($signed(px[c])) : longint'(px[c]);
        vy = sg ? longint'($signed(py[c])) : longint'(py[c]);
        if (clr) begin
          m_res[c] = '0; m_ovf[c] = 0;
        end else if (ce) begin
          if (!accum) begin
            r = e_add ? vx + vy : vx - vy;
            m_res[c] = r[AW-1:0]; m_ovf[c] = 0;
          end else if (e_ld) begin
            m_res[c] = vx[AW-1:0]; m_ovf[c] = 0;
          end else begin
            cur = sg ? longint'($signed(m_res[c])) : longint'(m_res[c]);
            r = e_add ? cur + vx : cur - vx;
            if (sg) m_ovf[c] = (r < -(64'sd1 << (AW-1))) || (r > (64'sd1 << (AW-1)) - 1);
            else    m_ovf[c] = (r < 0) || (r > (64'sd1 << AW) - 1);
            m_res[c] = r[AW-1:0];
          end
        end
        if (ce) begin
          h_add[c][2] = h_add[c][1]; h_add[c][1] = add[c];
          h_ld[c][2]  = h_ld[c][1];  h_ld[c][1]  = load[c];
        end
      end
      if (ce) begin
        h_sa[2] = h_sa[1]; h_sa[1] = sa;
        h_sb[2] = h_sb[1]; h_sb[1] = sb;
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s act=%0h exp=%0h", phase, what, act, exp);
    end
  endtask

  bit saw_ovf = 0;
  task automatic tick();
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      chk($sformatf("res[%0d]", c), 64'(res[c]), 64'(m_res[c]));
      chk($sformatf("ovf[%0d]", c), 64'(ovf[c]), 64'(m_ovf[c]));
      if (ovf[c]) saw_ovf = 1;
    end
  endtask

  task automatic rnd_data();
    for (int c = 0; c < NC; c++) begin
      px[c] = PW'($urandom); py[c] = PW'($urandom);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      chk("R1 res at reset", 64'(res[c]), 64'd0);
      chk("R1 ovf at reset", 64'(ovf[c]), 64'd0);
    end
    rst_n = 1'b1; ce = 1'b1;

    phase = "R2 pair mode";
    for (int i = 0; i < 24; i++) begin
      rnd_data(); add = NC'($urandom); sa = (i / 6) % 2 == 1; sb = 0;
      tick();
    end

    phase = "R12 channel independence";
    add = 2'b01;
    for (int i = 0; i < 6; i++) begin rnd_data(); tick(); end

    phase = "R6 sign extension";
    for (int i = 0; i < 10; i++) begin
      rnd_data(); px[0][PW-1] = 1'b1; sb = i[0]; add = 2'b10; tick();
    end
    sb = 0;

    phase = "R3 accumulate";
    accum = 1;
    for (int i = 0; i < 30; i++) begin
      rnd_data(); add = NC'($urandom); load = (($urandom % 6) == 0) ? 2'b11 : 2'b00;
      sa = i >= 15; tick();
    end

    phase = "R8 unsigned carry";
    sa = 0; sb = 0; add = 2'b11; px = '0; load = 2'b11;
    repeat (4) tick();
    load = '0; saw_ovf = 0;
    for (int c = 0; c < NC; c++) px[c] = {PW{1'b1}};
    repeat (22) tick();
    chk("R8 carry flag seen", 64'(saw_ovf), 64'd1);

    phase = "R9 flag not sticky";
    px = '0;
    repeat (4) tick();

    phase = "R8 unsigned borrow";
    load = 2'b11; repeat (3) tick();
    load = '0; add = 2'b00; saw_ovf = 0;
    for (int c = 0; c < NC; c++) px[c] = 16'h0003;
    repeat (4) tick();
    chk("R8 borrow flag seen", 64'(saw_ovf), 64'd1);

    phase = "R7 signed underflow";
    sa = 1; add = 2'b11; px = '0; load = 2'b11;
    repeat (4) tick();
    load = '0; saw_ovf = 0;
    for (int c = 0; c < NC; c++) px[c] = 16'h8000;
    repeat (20) tick();
    chk("R7 signed flag seen", 64'(saw_ovf), 64'd1);

    phase = "R4 load clears flag";
    load = 2'b11; rnd_data(); repeat (4) tick();
    load = '0;

    phase = "R10 clear";
    clr = 1; rnd_data(); repeat (2) tick();
    clr = 0; repeat (2) tick();

    phase = "R11 enable hold";
    ce = 0;
    for (int i = 0; i < 6; i++) begin
      rnd_data(); add = NC'($urandom); load = NC'($urandom); sa = $urandom; tick();
    end
    ce = 1;
    for (int i = 0; i < 8; i++) begin rnd_data(); tick(); end

    phase = "R5 control delays";
    for (int i = 0; i < 60; i++) begin
      rnd_data(); add = NC'($urandom); load = (($urandom % 4) == 0) ? NC'($urandom) : '0;
      sa = $urandom; sb = (($urandom % 3) == 0); ce = (($urandom % 5) != 0);
      clr = (($urandom % 25) == 0); accum = (($urandom % 8) != 0);
      tick();
    end
    finish_run();
  end
endmodule